// File: doc/BRIEF.md
# SCSI DMA Channel Controller

This block is the control and status section of a DMA channel that sits between an 8-bit SCSI bus controller and a system bus. A host programs it through a small 16-bit register port. The registers are a control/status word, a start address and a transfer count (each written as a high and a low 16-bit half), and a FIFO count. Bytes pass through an on-chip buffer FIFO. In receive mode they flow from the SCSI side to memory. In send mode they are prefetched from memory and handed to the SCSI side. The system-bus master is a plain request/acknowledge port that carries one byte per transaction, with an error input.

One enable bit has three jobs. It runs the engine. It passes the SCSI controller's interrupt to the host. It also cuts the host off from the SCSI controller's register window. A transfer count of zero keeps the engine still while it is enabled, so software can enable the channel only to catch an interrupt such as a reselection. Before enabling a real transfer, software loads the address and count with the channel disabled. After the transfer it disables the channel and reads the conflict and bus-error flags.

The buffer depth is a parameter. The default of 2 KiB keeps elaboration small, and a FIFO_AW of 13 gives the full 8 KiB buffer.

Top module: `scsi_dma_ctl`

## Requirements
- R1: After reset, the control word reads 0x0400, meaning all control bits are 0 and only the FIFO-empty status bit 10 is set. `sbc_rst_n`, `host_irq`, `mem_req` and `scsi_ack` are all low.
- R2: Control bits 3 and 2 are active-low releases. Bit 3 drives `sbc_rst_n` directly. While bit 2 is 0, the FIFO is held empty and the conflict flag (bit 8) and bus-error flag (bit 9) are cleared.
- R3: `host_irq` is high one cycle after `sbc_irq`, the enable bit (bit 1), an empty FIFO and a zero FIFO count all hold together. It is low otherwise.
- R4: While the transfer count is zero, a SCSI request gets no acknowledge and no data moves, even with the engine enabled.
- R5: Host accesses with `host_win` high are forwarded to the SCSI controller only while the enable bit is clear. While the enable bit is set, `sbc_rd` and `sbc_wr` stay low and the read returns 0. Every host read returns its data on `host_rdata` one cycle after `host_rd`.
- R6: The address register is register 1 (bits 23:16) and register 2 (bits 15:0). Bit 0 of a low-half write is forced to 0, so the start address is always even.
- R7: Receive mode (bit 0 = 0): each SCSI byte accepted gets a one-cycle `scsi_ack` and decrements the count. Bytes are written to memory in arrival order at consecutive addresses from the start address. A request stays stable until it is acknowledged.
- R8: Send mode (bit 0 = 1): the engine fetches exactly count bytes from consecutive addresses. It delivers them in order on `scsi_dout` together with `scsi_ack`.
- R9: `sbc_eop` pulses together with the acknowledge of the byte that takes the count from 1 to 0, and at no other time.
- R10: A host write to the address or count registers (1 to 4) while the engine is enabled with a nonzero count is dropped and sets the conflict flag, status bit 8.
- R11: A memory acknowledge with `mem_err` high sets the bus-error flag, status bit 9. No further memory request is issued until the flag is cleared.
- R12: The FIFO count register (5) decrements with each accepted SCSI byte and holds at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_win | input | 1 | 1 selects the SCSI controller window, 0 selects own registers |
| host_addr | input | 3 | Register or window address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid the cycle after host_rd |
| host_irq | output | 1 | Gated SCSI interrupt to the host |
| sbc_wr | output | 1 | Forwarded write to the SCSI controller |
| sbc_rd | output | 1 | Forwarded read to the SCSI controller |
| sbc_addr | output | 3 | SCSI controller register address |
| sbc_wdata | output | 8 | SCSI controller write data |
| sbc_rdata | input | 8 | SCSI controller read data |
| sbc_irq | input | 1 | SCSI controller interrupt |
| sbc_rst_n | output | 1 | SCSI reset, active low |
| sbc_eop | output | 1 | End-of-process pulse |
| scsi_req | input | 1 | SCSI side byte request |
| scsi_din | input | 8 | Byte from the SCSI side (receive) |
| scsi_ack | output | 1 | Byte accepted or delivered |
| scsi_dout | output | 8 | Byte to the SCSI side (send) |
| mem_req | output | 1 | System bus request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transaction complete |
| mem_err | input | 1 | Bus error, valid with mem_ack |

## Verification
The results arrive with different delays. Register writes take effect at the clock edge that samples the strobe, and read data appears on `host_rdata` one cycle after `host_rd`. `scsi_ack`, `scsi_dout` and `sbc_eop` appear one cycle after the request that moved the byte. `host_irq` trails its inputs by one register. Window strobes are combinational and follow `host_rd`/`host_wr` in the same cycle. The bench drives every stimulus at a falling edge. It reads each result at the next falling edge, or at the one after that for `host_irq` after a state change. Memory-side effects, such as write order, fetch count and the stop after an error, are checked only after a settling wait of a fixed number of cycles, longer than the worst-case three-cycle transaction.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  localparam int HOST_AW = 3;
  localparam int CNT_W   = 32;

  localparam logic [HOST_AW-1:0] A_CTRL    = 3'd0;
  localparam logic [HOST_AW-1:0] A_ADDR_HI = 3'd1;
  localparam logic [HOST_AW-1:0] A_ADDR_LO = 3'd2;
  localparam logic [HOST_AW-1:0] A_CNT_HI  = 3'd3;
  localparam logic [HOST_AW-1:0] A_CNT_LO  = 3'd4;
  localparam logic [HOST_AW-1:0] A_FCNT    = 3'd5;

  localparam int B_SEND    = 0;
  localparam int B_DMAEN   = 1;
  localparam int B_FIFORSN = 2;
  localparam int B_SCSIRSN = 3;

  typedef enum logic [1:0] {M_IDLE, M_LOAD, M_BUS} mstate_e;
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   level;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
    if (do_pop)  rdata   <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + (AW+1)'(1);
        2'b01:   level <= level - (AW+1)'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
  import scsi_dma_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic               host_win,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               host_irq,
  output logic               sbc_wr,
  output logic               sbc_rd,
  output logic [HOST_AW-1:0] sbc_addr,
  output logic [7:0]         sbc_wdata,
  input  logic [7:0]         sbc_rdata,
  input  logic               sbc_irq,
  output logic               sbc_rst_n,
  input  logic               fifo_empty,
  input  logic               scsi_byte,
  input  logic               addr_inc,
  input  logic               bus_err_set,
  output logic               dir_send,
  output logic               dma_en,
  output logic               fifo_rst_n,
  output logic               bus_err,
  output logic               cnt_nz,
  output logic               cnt_last,
  output logic [CNT_W-1:0]   cnt_val,
  output logic               cnt_load,
  output logic [ADDR_W-1:0]  addr_val
);
  logic [3:0]        ctrl_q;
  logic              conflict_q, bus_err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [15:0]       fcnt_q;
  logic              load_q;
  logic [15:0]       rd_val;
  logic              reg_wr, guarded, busy, drop_wr;

  assign dir_send   = ctrl_q[B_SEND];
  assign dma_en     = ctrl_q[B_DMAEN];
  assign fifo_rst_n = ctrl_q[B_FIFORSN];
  assign sbc_rst_n  = ctrl_q[B_SCSIRSN];
  assign bus_err    = bus_err_q;
  assign cnt_nz     = (cnt_q != '0);
  assign cnt_last   = (cnt_q == CNT_W'(1));
  assign cnt_val    = cnt_q;
  assign cnt_load   = load_q;
  assign addr_val   = addr_q;

  assign reg_wr  = host_wr && !host_win;
  assign guarded = (host_addr == A_ADDR_HI) || (host_addr == A_ADDR_LO) ||
                   (host_addr == A_CNT_HI)  || (host_addr == A_CNT_LO);
  assign busy    = dma_en && cnt_nz;
  assign drop_wr = guarded && busy;

  // controller window: blocked while the engine is enabled
  assign sbc_wr    = host_wr && host_win && !dma_en;
  assign sbc_rd    = host_rd && host_win && !dma_en;
  assign sbc_addr  = host_addr;
  assign sbc_wdata = host_wdata[7:0];

  always_comb begin
    case (host_addr)
      A_CTRL:    rd_val = {5'b0, fifo_empty, bus_err_q, conflict_q, 4'b0, ctrl_q};
      A_ADDR_HI: rd_val = 16'(addr_q[ADDR_W-1:16]);
      A_ADDR_LO: rd_val = addr_q[15:0];
      A_CNT_HI:  rd_val = cnt_q[CNT_W-1:16];
      A_CNT_LO:  rd_val = cnt_q[15:0];
      A_FCNT:    rd_val = fcnt_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      conflict_q <= 1'b0;
      bus_err_q  <= 1'b0;
      addr_q     <= '0;
      cnt_q      <= '0;
      fcnt_q     <= '0;
      load_q     <= 1'b0;
      host_rdata <= '0;
      host_irq   <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (reg_wr && host_addr == A_CTRL) ctrl_q <= host_wdata[3:0];

      if (!ctrl_q[B_FIFORSN]) begin
        conflict_q <= 1'b0;
        bus_err_q  <= 1'b0;
      end else begin
        if (bus_err_set) bus_err_q <= 1'b1;
        if (reg_wr && drop_wr) conflict_q <= 1'b1;
      end

      if (addr_inc) addr_q <= addr_q + ADDR_W'(1);
      if (scsi_byte && cnt_nz) cnt_q <= cnt_q - CNT_W'(1);
      if (scsi_byte && fcnt_q != '0) fcnt_q <= fcnt_q - 16'd1;

      if (reg_wr && !drop_wr) begin
        case (host_addr)
          A_ADDR_HI: addr_q[ADDR_W-1:16] <= host_wdata[ADDR_W-17:0];
          A_ADDR_LO: addr_q[15:0] <= {host_wdata[15:1], 1'b0};
          A_CNT_HI: begin
            cnt_q[CNT_W-1:16] <= host_wdata;
            load_q <= 1'b1;
          end
          A_CNT_LO: begin
            cnt_q[15:0] <= host_wdata;
            load_q <= 1'b1;
          end
          A_FCNT:  fcnt_q <= host_wdata;
          default: ;
        endcase
      end

      if (!host_rd)      host_rdata <= '0;
      else if (host_win) host_rdata <= dma_en ? 16'h0000 : {8'h00, sbc_rdata};
      else               host_rdata <= rd_val;

      host_irq <= sbc_irq && dma_en && fifo_empty && (fcnt_q == '0);
    end
  end
endmodule

// File: rtl/scsi_dma_engine.sv
module scsi_dma_engine
  import scsi_dma_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int FIFO_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_send,
  input  logic              dma_en,
  input  logic              fifo_rst_n,
  input  logic              bus_err,
  input  logic              cnt_nz,
  input  logic              cnt_last,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_load,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              scsi_req,
  input  logic [7:0]        scsi_din,
  output logic              scsi_ack,
  output logic [7:0]        scsi_dout,
  output logic              sbc_eop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              scsi_byte,
  output logic              addr_inc,
  output logic              bus_err_set,
  output logic              fifo_empty
);
  mstate_e          st;
  logic [CNT_W-1:0] fetch_left;
  logic             f_full, f_push, f_pop;
  logic [7:0]       f_wdata, f_rdata;
  logic             take, pop_mem, done;

  dma_fifo #(.AW(FIFO_AW), .DW(8)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (!fifo_rst_n),
    .push  (f_push),
    .wdata (f_wdata),
    .pop   (f_pop),
    .rdata (f_rdata),
    .empty (fifo_empty),
    .full  (f_full)
  );

  // SCSI side: one byte per cycle while the count is nonzero
  assign take = scsi_req && dma_en && cnt_nz && fifo_rst_n &&
                (dir_send ? !fifo_empty : !f_full);
  assign scsi_byte = take;
  assign scsi_dout = f_rdata;

  // memory side
  assign done        = (st == M_BUS) && mem_ack;
  assign addr_inc    = done;
  assign bus_err_set = done && mem_err;
  assign pop_mem     = (st == M_IDLE) && dma_en && fifo_rst_n && !bus_err &&
                       !dir_send && !fifo_empty;
  assign mem_addr    = addr_val;

  assign f_push  = dir_send ? (done && !mem_we && !mem_err) : take;
  assign f_wdata = dir_send ? mem_rdata : scsi_din;
  assign f_pop   = dir_send ? take : pop_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      scsi_ack <= 1'b0;
      sbc_eop  <= 1'b0;
    end else begin
      scsi_ack <= take;
      sbc_eop  <= take && cnt_last;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= M_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_wdata  <= '0;
      fetch_left <= '0;
    end else begin
      if (cnt_load) fetch_left <= cnt_val;
      case (st)
        M_IDLE: begin
          if (pop_mem) begin
            st <= M_LOAD;
          end else if (dma_en && fifo_rst_n && !bus_err && dir_send &&
                       fetch_left != '0 && !f_full && !cnt_load) begin
            mem_req <= 1'b1;
            mem_we  <= 1'b0;
            st      <= M_BUS;
          end
        end
        M_LOAD: begin
          mem_wdata <= f_rdata;
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          st        <= M_BUS;
        end
        M_BUS: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            st      <= M_IDLE;
            if (!mem_we && !mem_err) fetch_left <= fetch_left - CNT_W'(1);
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scsi_dma_ctl.sv
module scsi_dma_ctl
  import scsi_dma_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int FIFO_AW = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic               host_win,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               host_irq,
  output logic               sbc_wr,
  output logic               sbc_rd,
  output logic [HOST_AW-1:0] sbc_addr,
  output logic [7:0]         sbc_wdata,
  input  logic [7:0]         sbc_rdata,
  input  logic               sbc_irq,
  output logic               sbc_rst_n,
  output logic               sbc_eop,
  input  logic               scsi_req,
  input  logic [7:0]         scsi_din,
  output logic               scsi_ack,
  output logic [7:0]         scsi_dout,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  input  logic               mem_ack,
  input  logic               mem_err
);
  logic              dir_send, dma_en, fifo_rst_n, bus_err;
  logic              cnt_nz, cnt_last, cnt_load;
  logic [CNT_W-1:0]  cnt_val;
  logic [ADDR_W-1:0] addr_val;
  logic              fifo_empty, scsi_byte, addr_inc, bus_err_set;

  scsi_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_win    (host_win),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_irq    (host_irq),
    .sbc_wr      (sbc_wr),
    .sbc_rd      (sbc_rd),
    .sbc_addr    (sbc_addr),
    .sbc_wdata   (sbc_wdata),
    .sbc_rdata   (sbc_rdata),
    .sbc_irq     (sbc_irq),
    .sbc_rst_n   (sbc_rst_n),
    .fifo_empty  (fifo_empty),
    .scsi_byte   (scsi_byte),
    .addr_inc    (addr_inc),
    .bus_err_set (bus_err_set),
    .dir_send    (dir_send),
    .dma_en      (dma_en),
    .fifo_rst_n  (fifo_rst_n),
    .bus_err     (bus_err),
    .cnt_nz      (cnt_nz),
    .cnt_last    (cnt_last),
    .cnt_val     (cnt_val),
    .cnt_load    (cnt_load),
    .addr_val    (addr_val)
  );

  scsi_dma_engine #(.ADDR_W(ADDR_W), .FIFO_AW(FIFO_AW)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .dir_send    (dir_send),
    .dma_en      (dma_en),
    .fifo_rst_n  (fifo_rst_n),
    .bus_err     (bus_err),
    .cnt_nz      (cnt_nz),
    .cnt_last    (cnt_last),
    .cnt_val     (cnt_val),
    .cnt_load    (cnt_load),
    .addr_val    (addr_val),
    .scsi_req    (scsi_req),
    .scsi_din    (scsi_din),
    .scsi_ack    (scsi_ack),
    .scsi_dout   (scsi_dout),
    .sbc_eop     (sbc_eop),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .scsi_byte   (scsi_byte),
    .addr_inc    (addr_inc),
    .bus_err_set (bus_err_set),
    .fifo_empty  (fifo_empty)
  );
endmodule

// File: rtl/scsi_dma_ctl_chk.sv
module scsi_dma_ctl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              host_irq,
  input logic              dma_en,
  input logic              fifo_empty,
  input logic              scsi_ack,
  input logic              cnt_nz,
  input logic              sbc_eop,
  input logic              host_rd,
  input logic              host_win,
  input logic [15:0]       host_rdata,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              bus_err,
  input logic              fifo_rst_n
);
  p_fifo_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !fifo_rst_n |=> fifo_empty);

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> ($past(dma_en) && $past(fifo_empty)));

  p_zero_count_idle_r4: assert property (@(posedge clk) disable iff (rst)
    scsi_ack |-> $past(cnt_nz));

  p_window_block_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_win && dma_en) |=> (host_rdata == 16'h0000));

  p_bus_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_eop_last_r9: assert property (@(posedge clk) disable iff (rst)
    sbc_eop |-> (scsi_ack && !cnt_nz));

  p_err_stop_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_err && !mem_req) |=> !mem_req);
endmodule

bind scsi_dma_ctl scsi_dma_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_irq   (host_irq),
  .dma_en     (dma_en),
  .fifo_empty (fifo_empty),
  .scsi_ack   (scsi_ack),
  .cnt_nz     (cnt_nz),
  .sbc_eop    (sbc_eop),
  .host_rd    (host_rd),
  .host_win   (host_win),
  .host_rdata (host_rdata),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .bus_err    (bus_err),
  .fifo_rst_n (fifo_rst_n)
);

// File: tb/tb_scsi_dma_ctl.sv
`timescale 1ns/1ps
module tb_scsi_dma_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 0, host_rd = 0, host_win = 0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_irq;
  logic        sbc_wr, sbc_rd, sbc_rst_n, sbc_eop;
  logic [2:0]  sbc_addr;
  logic [7:0]  sbc_wdata;
  logic [7:0]  sbc_rdata = 8'h5A;
  logic        sbc_irq = 0;
  logic        scsi_req = 0;
  logic [7:0]  scsi_din = '0;
  logic        scsi_ack;
  logic [7:0]  scsi_dout;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 0, mem_err = 0;

  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  bit err_next = 0, done = 0;
  logic [7:0] mem [256];
  logic [15:0] v;

  always #2.5 clk = ~clk;

  scsi_dma_ctl dut (.*);

  // memory responder: one-cycle acknowledge per request
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack  = 1'b1;
        mem_err  = err_next;
        err_next = 1'b0;
        if (mem_we) begin
          mem[mem_addr[7:0]] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr[7:0]];
          rd_cnt++;
        end
      end else begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit win = 0);
    @(negedge clk);
    host_wr = 1; host_win = win; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_win = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d, input bit win = 0);
    @(negedge clk);
    host_rd = 1; host_win = win; host_addr = a;
    @(negedge clk);
    host_rd = 0; host_win = 0;
    d = host_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scsi_xfer(input logic [7:0] b, output bit ack, output bit eop,
                           output logic [7:0] dout);
    @(negedge clk);
    scsi_req = 1; scsi_din = b;
    @(negedge clk);
    scsi_req = 0;
    ack = scsi_ack; eop = sbc_eop; dout = scsi_dout;
  endtask

  task automatic t_reset();
    chk(sbc_rst_n == 0, "R1 sbc_rst_n", sbc_rst_n, 0);
    chk(host_irq == 0 && mem_req == 0 && scsi_ack == 0, "R1 outputs idle",
        {host_irq, mem_req, scsi_ack}, 0);
    rd(3'd0, v);
    chk(v == 16'h0400, "R1 control after reset", v, 16'h0400);
    wr(3'd0, 16'h000C);
    chk(sbc_rst_n == 1, "R2 scsi reset released", sbc_rst_n, 1);
    rd(3'd0, v);
    chk(v == 16'h040C, "R2 control readback", v, 16'h040C);
  endtask

  task automatic t_window();
    bit seen;
    @(negedge clk);
    host_rd = 1; host_win = 1; host_addr = 3'd2;
    #1 seen = sbc_rd;
    @(negedge clk);
    host_rd = 0; host_win = 0;
    chk(seen && host_rdata == 16'h005A, "R5 window forwarded", host_rdata, 16'h005A);
    wr(3'd0, 16'h000E);
    @(negedge clk);
    host_rd = 1; host_win = 1; host_addr = 3'd2;
    #1 seen = sbc_rd;
    @(negedge clk);
    host_rd = 0; host_win = 0;
    chk(!seen && host_rdata == 16'h0000, "R5 window blocked read", host_rdata, 0);
    @(negedge clk);
    host_wr = 1; host_win = 1; host_addr = 3'd1; host_wdata = 16'h0033;
    #1 seen = sbc_wr;
    @(negedge clk);
    host_wr = 0; host_win = 0;
    chk(!seen, "R5 window blocked write", seen, 0);
  endtask

  task automatic t_irq_zero();
    bit a, e; logic [7:0] d;
    int w0;
    w0 = rd_cnt + wr_cnt;
    sbc_irq = 1;
    idle(2);
    chk(host_irq == 1, "R3 irq passes when enabled", host_irq, 1);
    scsi_xfer(8'h77, a, e, d);
    chk(!a, "R4 no ack at zero count", a, 0);
    idle(4);
    chk(rd_cnt + wr_cnt == w0, "R4 no memory traffic at zero count", rd_cnt + wr_cnt, w0);
    wr(3'd5, 16'd3);
    idle(1);
    chk(host_irq == 0, "R3 fifo count masks irq", host_irq, 0);
    wr(3'd5, 16'd0);
    idle(1);
    chk(host_irq == 1, "R3 irq back", host_irq, 1);
    wr(3'd0, 16'h000C);
    idle(1);
    chk(host_irq == 0, "R3 disable masks irq", host_irq, 0);
    sbc_irq = 0;
  endtask

  task automatic t_addr();
    wr(3'd1, 16'h0012);
    wr(3'd2, 16'h3401);
    rd(3'd2, v);
    chk(v == 16'h3400, "R6 low half forced even", v, 16'h3400);
    rd(3'd1, v);
    chk(v == 16'h0012, "R6 high half", v, 16'h0012);
  endtask

  task automatic t_receive();
    bit a, e; logic [7:0] d;
    logic [7:0] pat [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    wr(3'd0, 16'h000C);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0040);
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'd4);
    wr(3'd5, 16'd2);
    wr(3'd0, 16'h000E);
    for (int i = 0; i < 4; i++) begin
      scsi_xfer(pat[i], a, e, d);
      chk(a, "R7 receive ack", a, 1);
      chk(e == (i == 3), "R9 eop only on last byte", e, (i == 3));
    end
    idle(20);
    chk(wr_cnt == 4, "R7 memory write count", wr_cnt, 4);
    for (int i = 0; i < 4; i++)
      chk(mem[8'h40 + i] == pat[i], "R7 receive order", mem[8'h40 + i], pat[i]);
    rd(3'd4, v);
    chk(v == 16'd0, "R7 count reaches zero", v, 0);
    rd(3'd5, v);
    chk(v == 16'd0, "R12 fifo count holds at zero", v, 0);
    scsi_xfer(8'hEE, a, e, d);
    chk(!a, "R4 no ack after count exhausted", a, 0);
  endtask

  task automatic t_send();
    bit a, e; logic [7:0] d;
    int r0;
    for (int i = 0; i < 6; i++) mem[8'h80 + i] = 8'h10 + 8'(i);
    wr(3'd0, 16'h000D);
    wr(3'd2, 16'h0080);
    wr(3'd4, 16'd3);
    wr(3'd5, 16'd3);
    r0 = rd_cnt;
    wr(3'd0, 16'h000F);
    idle(30);
    chk(rd_cnt - r0 == 3, "R8 fetches exactly count bytes", rd_cnt - r0, 3);
    for (int i = 0; i < 3; i++) begin
      scsi_xfer(8'h00, a, e, d);
      chk(a && d == 8'h10 + 8'(i), "R8 send data order", d, 8'h10 + i);
      chk(e == (i == 2), "R9 eop on final send byte", e, (i == 2));
    end
    rd(3'd5, v);
    chk(v == 16'd0, "R12 fifo count decremented", v, 0);
  endtask

  task automatic t_conflict();
    wr(3'd0, 16'h000C);
    wr(3'd2, 16'h0060);
    wr(3'd4, 16'd5);
    wr(3'd0, 16'h000E);
    wr(3'd2, 16'h0100);
    rd(3'd2, v);
    chk(v == 16'h0060, "R10 guarded write dropped", v, 16'h0060);
    rd(3'd0, v);
    chk(v == 16'h050E, "R10 conflict flag set", v, 16'h050E);
    wr(3'd0, 16'h0008);
    wr(3'd0, 16'h000C);
    rd(3'd0, v);
    chk(v == 16'h040C, "R2 fifo reset clears flags", v, 16'h040C);
  endtask

  task automatic t_bus_err();
    bit a, e; logic [7:0] d;
    int r0;
    wr(3'd0, 16'h000D);
    wr(3'd2, 16'h0090);
    wr(3'd4, 16'd2);
    r0 = rd_cnt;
    err_next = 1;
    wr(3'd0, 16'h000F);
    idle(20);
    chk(rd_cnt - r0 == 1, "R11 traffic stops after error", rd_cnt - r0, 1);
    rd(3'd0, v);
    chk(v == 16'h060F, "R11 bus error flag", v, 16'h060F);
    // FIFO filled while draining is blocked, then reset
    wr(3'd0, 16'h000C);
    wr(3'd4, 16'd2);
    wr(3'd0, 16'h000E);
    scsi_xfer(8'h55, a, e, d);
    scsi_xfer(8'h66, a, e, d);
    chk(a && e, "R9 eop on last receive byte", {a, e}, 3);
    sbc_irq = 1;
    idle(2);
    chk(host_irq == 0, "R3 non-empty fifo masks irq", host_irq, 0);
    sbc_irq = 0;
    rd(3'd0, v);
    chk(v == 16'h020E, "R11 fifo holds bytes while stopped", v, 16'h020E);
    wr(3'd0, 16'h0008);
    rd(3'd0, v);
    chk(v == 16'h0408, "R2 fifo reset empties fifo", v, 16'h0408);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_window();
    t_irq_zero();
    t_addr();
    t_receive();
    t_send();
    t_conflict();
    t_bus_err();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule